// File: doc/BRIEF.md
# UART Modem Control and Diagnostic Loopback

This block holds the modem-control register of a serial port and the steering logic around the serial and handshake pins. A bus write sets the request-to-send level, the interrupt gate, the loopback switch and the automatic flow-control enable. The block then decides what drives the TX pin, which bit the receive shifter sees, what the RTS pin shows, and whether the raw interrupt request reaches the interrupt controller.

The four active-low modem inputs are synchronised and inverted into an active-high status vector. The block also keeps sticky change flags that a status-read strobe clears. In loopback, the serial path is turned back inside the block and the pins are ignored: the status vector is taken from register bits, so software can exercise the whole path without a cable.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset the control register reads 0. A write takes effect at the next clock edge. Only bit 5 (autoflow), bit 4 (loopback), bit 3 (interrupt gate) and bit 1 (RTS) are kept; every other bit reads back as 0.
- R2: `autoCtsEn` equals the autoflow bit. `autoRtsEn` equals the autoflow bit ANDed with the RTS bit.
- R3: With loopback off, `txPin` is `txShiftOut` forced low while `txBreak` is 1, and `rxToShifter` is `rxPin`. With loopback on, `txPin` is 1 and `rxToShifter` carries that same break-gated transmit value.
- R4: With loopback on, the pins are ignored. `modemStatus` is {RI=0, DCD=interrupt-gate bit, DSR=0, CTS=RTS bit}, so `ctsInternal` follows the RTS bit. `rtsPinN` is held at 1.
- R5: With loopback off, `modemStatus` bit 0 is CTS, bit 1 is DSR, bit 2 is DCD and bit 3 is RI. Each bit is the inverse of its pin, delayed by two clock edges. `ctsInternal` equals bit 0.
- R6: `irqOut` is `irqRaw` when loopback is on or the interrupt-gate bit is 1. Otherwise `irqOut` is 0.
- R7: Change flags in `modemDelta` use the same bit order as `modemStatus`. Bits 0 to 2 set one edge after any change of their status bit. Bit 3 sets one edge after RI status falls from 1 to 0. An edge with `statusRead` high clears all flags, except that a flag being set at that same edge stays set.
- R8: With loopback off, `rtsPinN` is the inverse of the RTS bit, except that it is 1 whenever `autoRtsEn` and `rxNearFull` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| wrEn | input | 1 | Control register write strobe |
| wrData | input | 8 | Control register write data |
| rdData | output | 8 | Control register readback |
| ctsPinN | input | 1 | Clear-to-send pin, active low |
| dsrPinN | input | 1 | Data-set-ready pin, active low |
| dcdPinN | input | 1 | Carrier-detect pin, active low |
| riPinN | input | 1 | Ring-indicator pin, active low |
| rxPin | input | 1 | Serial receive pin |
| txShiftOut | input | 1 | Transmit shifter output bit |
| txBreak | input | 1 | Transmitter break request |
| irqRaw | input | 1 | Raw UART interrupt request |
| rxNearFull | input | 1 | Receive buffer nearly full |
| statusRead | input | 1 | Status read strobe; clears change flags |
| txPin | output | 1 | Serial transmit pin |
| rtsPinN | output | 1 | Request-to-send pin, active low |
| ctsInternal | output | 1 | CTS as seen by the core |
| rxToShifter | output | 1 | Bit fed to the receive shifter |
| irqOut | output | 1 | Gated interrupt to the interrupt controller |
| autoCtsEn | output | 1 | Automatic CTS flow control enable |
| autoRtsEn | output | 1 | Automatic RTS flow control enable |
| modemStatus | output | 4 | Active-high modem status {RI, DCD, DSR, CTS} |
| modemDelta | output | 4 | Sticky change flags, same order |

## Verification
A status read and a fresh modem-line change can hit the change flags at the same clock edge. The bench provokes this by holding `statusRead` high across exactly the edge at which a CTS pin change reaches the flags, while a DSR flag set earlier is still pending. The collision is judged correct when the DSR flag is cleared and the CTS flag survives. A full 256-value write sweep also checks, for each value, the gating, the serial steering and the status source in both modes.

// File: rtl/uart_mctl_pkg.sv
package uart_mctl_pkg;
  localparam int REG_W     = 8;
  localparam int MODEM_N   = 4;
  localparam int AFE_BIT   = 5;
  localparam int LOOP_BIT  = 4;
  localparam int GATE_BIT  = 3;
  localparam int RTS_BIT   = 1;
  localparam logic [REG_W-1:0] RW_MASK =
    REG_W'((1 << AFE_BIT) | (1 << LOOP_BIT) | (1 << GATE_BIT) | (1 << RTS_BIT));

  typedef struct packed {
    logic afe;
    logic loop;
    logic gate;
    logic rts;
  } mctlBits_t;
endpackage

// File: rtl/mctl_regs.sv
module mctl_regs
  import uart_mctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output mctlBits_t        ctl
);
  logic [REG_W-1:0] regQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     regQ <= '0;
    else if (wrEn) regQ <= wrData & RW_MASK;
  end

  assign rdData   = regQ;
  assign ctl.afe  = regQ[AFE_BIT];
  assign ctl.loop = regQ[LOOP_BIT];
  assign ctl.gate = regQ[GATE_BIT];
  assign ctl.rts  = regQ[RTS_BIT];

  // R1
  write_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (ctl.loop == $past(wrData[LOOP_BIT])) && (ctl.rts == $past(wrData[RTS_BIT])));
endmodule

// File: rtl/mctl_datapath.sv
module mctl_datapath
  import uart_mctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  mctlBits_t          ctl,
  input  logic [MODEM_N-1:0] pinsN,
  input  logic               rxPin,
  input  logic               txShiftOut,
  input  logic               txBreak,
  input  logic               irqRaw,
  input  logic               rxNearFull,
  input  logic               statusRead,
  output logic               txPin,
  output logic               rtsPinN,
  output logic               ctsInternal,
  output logic               rxToShifter,
  output logic               irqOut,
  output logic               autoCtsEn,
  output logic               autoRtsEn,
  output logic [MODEM_N-1:0] modemStatus,
  output logic [MODEM_N-1:0] modemDelta
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [MODEM_N-1:0] syncQ [SYNC_STAGES];
  logic [MODEM_N-1:0] statusSel, prevStatus, edgeHit, loopStatus;
  logic               txLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '1;
    end else begin
      syncQ[0] <= pinsN;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  assign loopStatus = {1'b0, ctl.gate, 1'b0, ctl.rts};
  assign statusSel  = ctl.loop ? loopStatus : ~syncQ[LAST];
  assign edgeHit    = {prevStatus[3] & ~statusSel[3], statusSel[2:0] ^ prevStatus[2:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevStatus <= '0;
      modemDelta <= '0;
    end else begin
      prevStatus <= statusSel;
      modemDelta <= (statusRead ? '0 : modemDelta) | edgeHit;
    end
  end

  assign modemStatus = statusSel;
  assign ctsInternal = statusSel[0];

  assign txLine      = txShiftOut & ~txBreak;
  assign txPin       = ctl.loop ? 1'b1 : txLine;
  assign rxToShifter = ctl.loop ? txLine : rxPin;

  assign autoCtsEn = ctl.afe;
  assign autoRtsEn = ctl.afe & ctl.rts;
  assign rtsPinN   = ctl.loop | ~ctl.rts | (autoRtsEn & rxNearFull);
  assign irqOut    = irqRaw & (ctl.gate | ctl.loop);

  // R3
  loop_tx_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loop |-> txPin);
  // R4
  loop_rts_inactive_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loop |-> rtsPinN);
  // R6
  irq_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loop && !ctl.gate) |-> !irqOut);
  // R7
  cts_delta_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modemStatus[0] != prevStatus[0]) |=> modemDelta[0]);
  // R2
  auto_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    autoRtsEn |-> autoCtsEn);
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import uart_mctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       ctsPinN,
  input  logic       dsrPinN,
  input  logic       dcdPinN,
  input  logic       riPinN,
  input  logic       rxPin,
  input  logic       txShiftOut,
  input  logic       txBreak,
  input  logic       irqRaw,
  input  logic       rxNearFull,
  input  logic       statusRead,
  output logic       txPin,
  output logic       rtsPinN,
  output logic       ctsInternal,
  output logic       rxToShifter,
  output logic       irqOut,
  output logic       autoCtsEn,
  output logic       autoRtsEn,
  output logic [3:0] modemStatus,
  output logic [3:0] modemDelta
);
  mctlBits_t ctl;

  mctl_regs uRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .ctl(ctl)
  );

  mctl_datapath #(.SYNC_STAGES(2)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .pinsN({riPinN, dcdPinN, dsrPinN, ctsPinN}),
    .rxPin(rxPin), .txShiftOut(txShiftOut), .txBreak(txBreak),
    .irqRaw(irqRaw), .rxNearFull(rxNearFull), .statusRead(statusRead),
    .txPin(txPin), .rtsPinN(rtsPinN), .ctsInternal(ctsInternal),
    .rxToShifter(rxToShifter), .irqOut(irqOut), .autoCtsEn(autoCtsEn),
    .autoRtsEn(autoRtsEn), .modemStatus(modemStatus), .modemDelta(modemDelta)
  );
endmodule

// File: tb/uart_modem_ctl_test.sv
`timescale 1ns/1ps
module uart_modem_ctl_test;
  logic clk = 0, rstN = 0;
  logic wrEn = 0, rxPin = 1, txShiftOut = 1, txBreak = 0, irqRaw = 0;
  logic rxNearFull = 0, statusRead = 0;
  logic [7:0] wrData = 0;
  logic [3:0] pinsN = 4'hF;
  logic [7:0] rdData;
  logic txPin, rtsPinN, ctsInternal, rxToShifter, irqOut, autoCtsEn, autoRtsEn;
  logic [3:0] modemStatus, modemDelta;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_modem_ctl uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .ctsPinN(pinsN[0]), .dsrPinN(pinsN[1]), .dcdPinN(pinsN[2]), .riPinN(pinsN[3]),
    .rxPin(rxPin), .txShiftOut(txShiftOut), .txBreak(txBreak), .irqRaw(irqRaw),
    .rxNearFull(rxNearFull), .statusRead(statusRead), .txPin(txPin),
    .rtsPinN(rtsPinN), .ctsInternal(ctsInternal), .rxToShifter(rxToShifter),
    .irqOut(irqOut), .autoCtsEn(autoCtsEn), .autoRtsEn(autoRtsEn),
    .modemStatus(modemStatus), .modemDelta(modemDelta)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wrReg(logic [7:0] v);
    wrEn = 1; wrData = v; tick(); wrEn = 0;
  endtask

  task automatic clearDeltas();
    statusRead = 1; tick(); statusRead = 0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); rstN = 1; @(negedge clk);
    // R1 reset state
    chk("R1 reset rd", rdData, 8'h00);
    chk("R7 reset delta", {4'h0, modemDelta}, 8'h00);
    chk("R5 reset status", {4'h0, modemStatus}, 8'h00);
    irqRaw = 1;
    chk("R6 reset irq", {7'h0, irqOut}, 8'h00);

    // Full write sweep
    for (int v = 0; v < 256; v++) begin
      logic afe, lp, gate, rts;
      logic [3:0] expStat;
      afe = v[5]; lp = v[4]; gate = v[3]; rts = v[1];
      pinsN = v[3:0] ^ v[7:4];
      wrReg(8'(v));
      chk("R1 readback", rdData, 8'(v) & 8'h3A);
      chk("R2 autoCts", {7'h0, autoCtsEn}, {7'h0, afe});
      chk("R2 autoRts", {7'h0, autoRtsEn}, {7'h0, afe & rts});
      if (lp) begin
        expStat = {1'b0, gate, 1'b0, rts};
        chk("R4 loop status", {4'h0, modemStatus}, {4'h0, expStat});
        chk("R4 loop cts", {7'h0, ctsInternal}, {7'h0, rts});
      end
      for (int c = 0; c < 4; c++) begin
        irqRaw = c[0]; rxNearFull = c[1];
        #1;
        chk("R6 irq", {7'h0, irqOut}, {7'h0, c[0] & (gate | lp)});
        if (lp) chk("R4 rts pin", {7'h0, rtsPinN}, 8'h01);
        else chk("R8 rts pin", {7'h0, rtsPinN}, {7'h0, ~(rts & ~(afe & c[1]))});
      end
      for (int s = 0; s < 8; s++) begin
        txShiftOut = s[0]; txBreak = s[1]; rxPin = s[2];
        #1;
        if (lp) begin
          chk("R3 loop tx", {7'h0, txPin}, 8'h01);
          chk("R3 loop rx", {7'h0, rxToShifter}, {7'h0, s[0] & ~s[1]});
        end else begin
          chk("R3 norm tx", {7'h0, txPin}, {7'h0, s[0] & ~s[1]});
          chk("R3 norm rx", {7'h0, rxToShifter}, {7'h0, s[2]});
        end
      end
      tick(); tick();
      expStat = lp ? {1'b0, gate, 1'b0, rts} : ~pinsN;
      chk("R5 status source", {4'h0, modemStatus}, {4'h0, expStat});
      chk("R5 ctsInternal", {7'h0, ctsInternal}, {7'h0, expStat[0]});
      clearDeltas();
    end

    // Normal-mode latency and deltas
    wrReg(8'h00); pinsN = 4'hF; tick(); tick(); tick(); clearDeltas();
    chk("R7 cleared", {4'h0, modemDelta}, 8'h00);
    pinsN[0] = 0;                 // CTS active
    tick();
    chk("R5 latency edge1", {4'h0, modemStatus}, 8'h00);
    tick();
    chk("R5 latency edge2", {4'h0, modemStatus}, 8'h01);
    chk("R7 delta not yet", {4'h0, modemDelta}, 8'h00);
    tick();
    chk("R7 cts delta set", {4'h0, modemDelta}, 8'h01);
    tick();
    chk("R7 sticky", {4'h0, modemDelta}, 8'h01);
    clearDeltas();
    chk("R7 read clears", {4'h0, modemDelta}, 8'h00);

    // RI: only trailing edge flags
    pinsN[3] = 0; tick(); tick(); tick(); tick();
    chk("R7 ri rise no flag", {4'h0, modemDelta}, 8'h00);
    pinsN[3] = 1; tick(); tick(); tick();
    chk("R7 ri trailing flag", {4'h0, modemDelta}, 8'h08);
    clearDeltas();

    // Collision: pending DSR flag, read at the edge a CTS change lands
    pinsN[1] = 0; tick(); tick(); tick();
    chk("R7 dsr pending", {4'h0, modemDelta}, 8'h02);
    pinsN[0] = 1; tick(); tick();
    statusRead = 1; tick(); statusRead = 0;
    chk("R7 set beats clear", {4'h0, modemDelta}, 8'h01);
    clearDeltas();

    // Loopback: pins ignored, deltas come from register bits
    pinsN = 4'hF; tick(); tick(); tick(); clearDeltas();
    wrReg(8'h10);
    tick(); clearDeltas();
    pinsN = 4'h0; tick(); tick(); tick();
    chk("R4 pins ignored", {4'h0, modemStatus}, 8'h00);
    chk("R4 no pin deltas", {4'h0, modemDelta}, 8'h00);
    wrReg(8'h1A);
    chk("R4 bits drive status", {4'h0, modemStatus}, 8'h05);
    tick();
    chk("R7 loop deltas", {4'h0, modemDelta}, 8'h05);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule